// File: doc/BRIEF.md
# Coupling-Fault Injecting Bit Memory

This block is a single-port memory, one bit wide, whose cells can be made to misbehave as if two of them were coupled by a defect. It acts as a stand-in device under test when a memory self-test controller is brought up. The controller sees an ordinary bit-wide RAM: an address, a write enable, a read enable, a write data bit and a registered read data bit. A set of configuration inputs names one aggressor cell and one victim cell. The same inputs pick one fault class and the three pattern bits x, y and z that the class compares against.

At most one operation sensitizes each fault class. Some classes need no access at all. Some fire on any access to the aggressor. Others act on a write or a read of the victim while the aggressor holds x. The read classes can return wrong data, corrupt the stored bit, or do both. An optional dynamic setting limits the read classes to a victim read that comes in the cycle directly after a write to the victim. With injection disabled, or with the aggressor and victim at the same address, the block is a plain RAM.

Top module: `cfm_coupling_ram`

## Requirements
- R1: While rst_n is low every cell clears to 0 and rdata clears to 0.
- R2: With injection inactive, a write (we=1) stores wdata at addr. A read (re=1, we=0) presents the bit at addr on rdata one clock later. rdata holds its value in every cycle without a read. A cycle with both we and re is only a write and leaves rdata unchanged.
- R3: Injection is active only when fault_en=1, aggr_addr differs from vict_addr and fault_kind is 0 to 6. Code 7, fault_en=0 or equal addresses all give R2 behaviour.
- R4: fault_kind=0 (state coupling). At any clock edge where the aggressor holds x, the victim holds y and the victim is not being written, the victim becomes not-y. No access is needed.
- R5: fault_kind=1 (disturb). A read of the aggressor, or a write of y to it, inverts the victim when the aggressor holds x and the victim holds z before the operation. A write that does not change the aggressor also counts. The aggressor write itself still takes effect.
- R6: fault_kind=2 (transition). A write to the victim that would change its value has no effect while the aggressor holds x.
- R7: fault_kind=3 (write destructive). A write of y to a victim already holding y, while the aggressor holds x, leaves not-y in the victim.
- R8: fault_kind=4 (read destructive). A victim read with the aggressor at x and the victim at y inverts the victim and returns not-y.
- R9: fault_kind=5 (incorrect read). Under the R8 condition the read returns not-y and the victim keeps y.
- R10: fault_kind=6 (deceptive read). Under the R8 condition the read returns y and the victim then holds not-y.
- R11: With dyn_en=1, kinds 4 to 6 fire only if the cycle just before the read was a write to the victim address. With dyn_en=0 they fire on any qualifying victim read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Cell address of the current operation |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable (ignored when we=1) |
| wdata | input | 1 | Write data bit |
| rdata | output | 1 | Registered read data |
| fault_en | input | 1 | Enables fault injection |
| aggr_addr | input | ADDR_W | Aggressor cell address |
| vict_addr | input | ADDR_W | Victim cell address |
| fault_kind | input | 3 | Fault class code 0 to 7 |
| lvl_x | input | 1 | Aggressor pattern bit x |
| lvl_y | input | 1 | Victim or written pattern bit y |
| lvl_z | input | 1 | Victim pattern bit z for disturb |
| dyn_en | input | 1 | Write-then-read qualification for read classes |

## Verification
The assertions compare the victim bit across a clock edge, so they assume that vict_addr, aggr_addr and the pattern bits stay constant from the operation in question until the next edge. The stimulus changes the configuration only between two idle cycles, so no checked operation is next to a configuration change. The assertions also assume that we and re are never unknown after reset. The bench drives every operation through one task and never leaves either input floating.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

  typedef enum logic [2:0] {
    FK_STATE      = 3'd0,
    FK_DISTURB    = 3'd1,
    FK_TRANSITION = 3'd2,
    FK_WR_DESTR   = 3'd3,
    FK_RD_DESTR   = 3'd4,
    FK_RD_WRONG   = 3'd5,
    FK_RD_DECEPT  = 3'd6,
    FK_NONE       = 3'd7
  } fault_kind_e;

endpackage

// File: rtl/cfm_fault_ctl.sv
// Decides, per cycle, what the array and the read port do: the normal write,
// a forced update of the victim cell, and inversion of returned data.
module cfm_fault_ctl
  import cfm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdata,
  input  logic              fault_en,
  input  logic [ADDR_W-1:0] aggr_addr,
  input  logic [ADDR_W-1:0] vict_addr,
  input  fault_kind_e       kind,
  input  logic              cx,
  input  logic              cy,
  input  logic              cz,
  input  logic              dyn_en,
  input  logic              a_bit,
  input  logic              v_bit,
  input  logic              wv_last,
  output logic              wr_en,
  output logic              wr_val,
  output logic              frc_en,
  output logic              frc_val,
  output logic              rd_en,
  output logic              rd_inv
);

  logic armed;
  logic op_wr;
  logic op_rd;
  logic hit_a;
  logic hit_v;
  logic agg_ok;
  logic rd_trig;

  always_comb begin
    armed   = fault_en && (aggr_addr != vict_addr);
    op_wr   = we;
    op_rd   = re && !we;
    hit_a   = (addr == aggr_addr);
    hit_v   = (addr == vict_addr);
    agg_ok  = armed && (a_bit == cx);
    rd_trig = agg_ok && op_rd && hit_v && (v_bit == cy) && (!dyn_en || wv_last);

    wr_en   = op_wr;
    wr_val  = wdata;
    frc_en  = 1'b0;
    frc_val = 1'b0;
    rd_en   = op_rd;
    rd_inv  = 1'b0;

    case (kind)
      FK_STATE: begin
        if (agg_ok && (v_bit == cy) && !(op_wr && hit_v)) begin
          frc_en  = 1'b1;
          frc_val = ~cy;
        end
      end
      FK_DISTURB: begin
        if (agg_ok && hit_a && (v_bit == cz) && ((op_wr && (wdata == cy)) || op_rd)) begin
          frc_en  = 1'b1;
          frc_val = ~cz;
        end
      end
      FK_TRANSITION: begin
        if (agg_ok && op_wr && hit_v && (wdata != v_bit)) begin
          wr_en = 1'b0;
        end
      end
      FK_WR_DESTR: begin
        if (agg_ok && op_wr && hit_v && (wdata == cy) && (v_bit == cy)) begin
          wr_val = ~cy;
        end
      end
      FK_RD_DESTR: begin
        if (rd_trig) begin
          frc_en  = 1'b1;
          frc_val = ~cy;
          rd_inv  = 1'b1;
        end
      end
      FK_RD_WRONG: begin
        if (rd_trig) begin
          rd_inv = 1'b1;
        end
      end
      FK_RD_DECEPT: begin
        if (rd_trig) begin
          frc_en  = 1'b1;
          frc_val = ~cy;
        end
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/cfm_bit_array.sv
// Bit storage with one normal write port, one forced victim update and
// three read taps (operation address, aggressor, victim).
module cfm_bit_array #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_val,
  input  logic              frc_en,
  input  logic [ADDR_W-1:0] frc_addr,
  input  logic              frc_val,
  input  logic [ADDR_W-1:0] aggr_addr,
  input  logic [ADDR_W-1:0] vict_addr,
  output logic              rd_bit,
  output logic              a_bit,
  output logic              v_bit
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] cell_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic sel_wr;
    logic sel_frc;
    logic ce;
    logic d;

    always_comb begin
      sel_wr  = wr_en  && (wr_addr  == ADDR_W'(i));
      sel_frc = frc_en && (frc_addr == ADDR_W'(i));
      ce      = sel_wr || sel_frc;
      d       = sel_wr ? wr_val : frc_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q[i] <= 1'b0;
      end else if (ce) begin
        cell_q[i] <= d;
      end
    end
  end

  assign rd_bit = cell_q[wr_addr];
  assign a_bit  = cell_q[aggr_addr];
  assign v_bit  = cell_q[vict_addr];

endmodule

// File: rtl/cfm_read_port.sv
// Registered read data plus the one-cycle "victim just written" flag.
module cfm_read_port #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_bit,
  input  logic              rd_inv,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] vict_addr,
  output logic              rdata,
  output logic              wv_last
);

  logic rdata_d;
  logic wv_d;
  logic rdata_q;
  logic wv_q;

  always_comb begin
    rdata_d = rd_bit ^ rd_inv;
    wv_d    = we && (addr == vict_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 1'b0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wv_q <= 1'b0;
    end else begin
      wv_q <= wv_d;
    end
  end

  assign rdata   = rdata_q;
  assign wv_last = wv_q;

endmodule

// File: rtl/cfm_coupling_ram.sv
module cfm_coupling_ram
  import cfm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  input  logic              wdata,
  output logic              rdata,
  input  logic              fault_en,
  input  logic [ADDR_W-1:0] aggr_addr,
  input  logic [ADDR_W-1:0] vict_addr,
  input  logic [2:0]        fault_kind,
  input  logic              lvl_x,
  input  logic              lvl_y,
  input  logic              lvl_z,
  input  logic              dyn_en
);

  fault_kind_e kind_sel;
  logic        wr_en;
  logic        wr_val;
  logic        frc_en;
  logic        frc_val;
  logic        rd_en;
  logic        rd_inv;
  logic        rd_bit;
  logic        a_bit;
  logic        v_bit;
  logic        wv_last;

  assign kind_sel = fault_kind_e'(fault_kind);

  cfm_fault_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .we        (we),
    .re        (re),
    .addr      (addr),
    .wdata     (wdata),
    .fault_en  (fault_en),
    .aggr_addr (aggr_addr),
    .vict_addr (vict_addr),
    .kind      (kind_sel),
    .cx        (lvl_x),
    .cy        (lvl_y),
    .cz        (lvl_z),
    .dyn_en    (dyn_en),
    .a_bit     (a_bit),
    .v_bit     (v_bit),
    .wv_last   (wv_last),
    .wr_en     (wr_en),
    .wr_val    (wr_val),
    .frc_en    (frc_en),
    .frc_val   (frc_val),
    .rd_en     (rd_en),
    .rd_inv    (rd_inv)
  );

  cfm_bit_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (addr),
    .wr_val    (wr_val),
    .frc_en    (frc_en),
    .frc_addr  (vict_addr),
    .frc_val   (frc_val),
    .aggr_addr (aggr_addr),
    .vict_addr (vict_addr),
    .rd_bit    (rd_bit),
    .a_bit     (a_bit),
    .v_bit     (v_bit)
  );

  cfm_read_port #(.ADDR_W(ADDR_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_bit    (rd_bit),
    .rd_inv    (rd_inv),
    .we        (we),
    .addr      (addr),
    .vict_addr (vict_addr),
    .rdata     (rdata),
    .wv_last   (wv_last)
  );

endmodule

// File: rtl/cfm_coupling_ram_chk.sv
module cfm_coupling_ram_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              we,
  input logic              re,
  input logic              wdata,
  input logic              rdata,
  input logic              fault_en,
  input logic [ADDR_W-1:0] aggr_addr,
  input logic [ADDR_W-1:0] vict_addr,
  input logic [2:0]        fault_kind,
  input logic              lvl_x,
  input logic              lvl_y,
  input logic              lvl_z,
  input logic              dyn_en,
  input logic              rd_bit,
  input logic              a_bit,
  input logic              v_bit,
  input logic              frc_en,
  input logic              rd_inv
);

  logic armed;
  logic vrd;
  assign armed = fault_en && (aggr_addr != vict_addr);
  assign vrd   = re && !we && (addr == vict_addr) && (a_bit == lvl_x) && (v_bit == lvl_y);

  AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && re) |=> $stable(rdata)); // R2

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata)); // R2

  AST_IDEAL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_en && re && !we) |=> (rdata == $past(rd_bit))); // R2

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!frc_en && !rd_inv)); // R3

  AST_STATE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && fault_kind == 3'd0 && a_bit == lvl_x && v_bit == lvl_y
     && !(we && addr == vict_addr)) |=> (v_bit != $past(v_bit))); // R4

  AST_DISTURB_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && fault_kind == 3'd1 && re && !we && addr == aggr_addr
     && a_bit == lvl_x && v_bit == lvl_z) |=> (v_bit != $past(v_bit))); // R5

  AST_TRANS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && fault_kind == 3'd2 && we && addr == vict_addr && a_bit == lvl_x
     && wdata != v_bit) |=> (v_bit == $past(v_bit))); // R6

  AST_WRONG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && fault_kind == 3'd5 && !dyn_en && vrd)
    |=> (rdata != $past(v_bit)) && (v_bit == $past(v_bit))); // R9

  AST_DECEPT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && fault_kind == 3'd6 && !dyn_en && vrd)
    |=> (rdata == $past(v_bit)) && (v_bit != $past(v_bit))); // R10

endmodule

bind cfm_coupling_ram cfm_coupling_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .we         (we),
  .re         (re),
  .wdata      (wdata),
  .rdata      (rdata),
  .fault_en   (fault_en),
  .aggr_addr  (aggr_addr),
  .vict_addr  (vict_addr),
  .fault_kind (fault_kind),
  .lvl_x      (lvl_x),
  .lvl_y      (lvl_y),
  .lvl_z      (lvl_z),
  .dyn_en     (dyn_en),
  .rd_bit     (rd_bit),
  .a_bit      (a_bit),
  .v_bit      (v_bit),
  .frc_en     (frc_en),
  .rd_inv     (rd_inv)
);

// File: tb/sim_cfm_coupling_ram.sv
module sim_cfm_coupling_ram;

  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          we, re, wdata;
  logic          rdata;
  logic          fault_en;
  logic [AW-1:0] aggr_addr, vict_addr;
  logic [2:0]    fault_kind;
  logic          lvl_x, lvl_y, lvl_z, dyn_en;

  always #5 clk = ~clk;

  cfm_coupling_ram #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .re(re), .wdata(wdata),
    .rdata(rdata), .fault_en(fault_en), .aggr_addr(aggr_addr),
    .vict_addr(vict_addr), .fault_kind(fault_kind), .lvl_x(lvl_x),
    .lvl_y(lvl_y), .lvl_z(lvl_z), .dyn_en(dyn_en)
  );

  typedef struct {bit exp; int req;} exp_t;
  exp_t sbq[$];

  bit mdl[DEPTH];
  bit prev_wv = 1'b0;
  int cur_req = 0;
  int checks  = 0;
  int fails   = 0;
  bit pend_rd = 1'b0;
  int cyc_cnt = 0;

  // configuration applied with the next cycle
  bit c_en = 0; int c_ag = 0; int c_vc = 1; int c_kind = 7;
  bit c_x = 0, c_y = 0, c_z = 0, c_dyn = 0;

  task automatic check(bit ok, int req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // One clock cycle: drive inputs and advance the reference model.
  task automatic cyc(bit w, bit r, int a, bit d);
    bit armed, ax, av, vv, opr, hv, ha, fire;
    bit nw_en, nw_val, f_en, f_val, inv;
    @(negedge clk);
    fault_en = c_en; aggr_addr = AW'(c_ag); vict_addr = AW'(c_vc);
    fault_kind = 3'(c_kind); lvl_x = c_x; lvl_y = c_y; lvl_z = c_z; dyn_en = c_dyn;
    we = w; re = r; addr = AW'(a); wdata = d;

    armed = c_en && (c_ag != c_vc);
    av = mdl[c_ag]; vv = mdl[c_vc]; ax = armed && (av == c_x);
    opr = r && !w; hv = (a == c_vc); ha = (a == c_ag);
    nw_en = w; nw_val = d; f_en = 0; f_val = 0; inv = 0;
    fire = ax && opr && hv && (vv == c_y) && (!c_dyn || prev_wv);
    case (c_kind)
      0: if (ax && vv == c_y && !(w && hv)) begin f_en = 1; f_val = !c_y; end
      1: if (ax && ha && vv == c_z && ((w && d == c_y) || opr)) begin f_en = 1; f_val = !c_z; end
      2: if (ax && w && hv && d != vv) nw_en = 0;
      3: if (ax && w && hv && d == c_y && vv == c_y) nw_val = !c_y;
      4: if (fire) begin f_en = 1; f_val = !c_y; inv = 1; end
      5: if (fire) inv = 1;
      6: if (fire) begin f_en = 1; f_val = !c_y; end
      default: ;
    endcase
    if (opr) sbq.push_back('{exp: mdl[a] ^ inv, req: cur_req});
    if (nw_en) mdl[a] = nw_val;
    if (f_en) mdl[c_vc] = f_val;
    prev_wv = w && hv;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0);
  endtask

  task automatic set_cfg(bit en, int ag, int vc, int k, bit x, bit y, bit z, bit dn);
    idle();
    c_en = en; c_ag = ag; c_vc = vc; c_kind = k; c_x = x; c_y = y; c_z = z; c_dyn = dn;
    idle();
  endtask

  // Generic sensitizing sequence over one aggressor/victim pair.
  task automatic run_seq(int ag, int vc, bit x, bit y, bit z);
    cyc(1, 0, ag, x); cyc(1, 0, vc, y); idle();
    cyc(0, 1, vc, 0); cyc(0, 1, ag, 0);
    cyc(1, 0, ag, z); cyc(0, 1, vc, 0);
    cyc(1, 0, vc, y); cyc(0, 1, vc, 0);
    cyc(1, 0, ag, x); cyc(1, 0, vc, z); cyc(0, 1, ag, 0); cyc(0, 1, vc, 0);
    cyc(1, 0, ag, x); cyc(1, 0, vc, z); cyc(1, 0, ag, y); cyc(0, 1, vc, 0);
    cyc(1, 0, vc, !z); cyc(0, 1, vc, 0);
    cyc(1, 0, vc, y); cyc(0, 1, vc, 0); cyc(0, 1, vc, 0);
    idle(); cyc(0, 1, vc, 0); cyc(0, 1, ag, 0);
  endtask

  always @(posedge clk) pend_rd <= rst_n && re && !we;

  always @(negedge clk) begin
    exp_t it;
    if (pend_rd) begin
      if (sbq.size() == 0) begin
        check(1'b0, 0, "read with no expected item", rdata, 0);
      end else begin
        it = sbq.pop_front();
        check(rdata === it.exp, it.req, "read data", rdata, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cyc_cnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit held;
    rst_n = 0; we = 0; re = 0; addr = '0; wdata = 0;
    fault_en = 0; aggr_addr = '0; vict_addr = AW'(1); fault_kind = 3'd7;
    lvl_x = 0; lvl_y = 0; lvl_z = 0; dyn_en = 0;
    for (int i = 0; i < DEPTH; i++) mdl[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: reset state of read data and cells
    check(rdata === 1'b0, 1, "rdata after reset", rdata, 0);
    cur_req = 1;
    for (int i = 0; i < DEPTH; i += 7) cyc(0, 1, i, 0);

    // R2: plain RAM behaviour
    cur_req = 2;
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, i, bit'(i[0] ^ i[2]));
    for (int i = 0; i < DEPTH; i++) cyc(0, 1, i, 0);
    cyc(0, 1, 4, 0); idle(); idle();
    held = rdata;
    cyc(1, 1, 4, 0); idle();
    check(rdata === held, 2, "rdata after write+read cycle", rdata, held);
    idle(); check(rdata === held, 2, "rdata hold when idle", rdata, held);
    cyc(0, 1, 4, 0); idle();

    // R3: injection inactive cases
    cur_req = 3;
    set_cfg(1, 6, 6, 5, 0, 0, 0, 0); run_seq(6, 6, 0, 0, 0);
    set_cfg(0, 3, 9, 4, 1, 1, 0, 0); run_seq(3, 9, 1, 1, 0);
    set_cfg(1, 3, 9, 7, 0, 1, 1, 0); run_seq(3, 9, 0, 1, 1);

    // R4..R10 static classes, R11 dynamic read classes
    for (int k = 0; k < 7; k++) begin
      for (int dn = 0; dn < 2; dn++) begin
        for (int p = 0; p < 2; p++) begin
          for (int c = 0; c < 8; c++) begin
            int ag, vc;
            ag = (p == 0) ? 3 : 20;
            vc = (p == 0) ? 17 : 5;
            set_cfg(1, ag, vc, k, c[2], c[1], c[0], bit'(dn));
            if (dn == 1 && k >= 4) cur_req = 11;   // R11
            else cur_req = 4 + k;                  // R4 R5 R6 R7 R8 R9 R10
            run_seq(ag, vc, c[2], c[1], c[0]);
          end
        end
      end
    end

    set_cfg(0, 0, 1, 7, 0, 0, 0, 0);
    cur_req = 2;
    cyc(0, 1, 17, 0); cyc(0, 1, 3, 0);
    repeat (4) idle();
    check(sbq.size() == 0, 2, "scoreboard drained", sbq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule